// File: doc/BRIEF.md
# Four-Lane Pixel Word Aligner with Lane Deskew

This block sits behind four deserialized sensor lanes. Each lane delivers one 4-bit nibble per cycle of a clock at half the serial bit rate. The four lanes come as two channels of two ports each. For each lane, the block assembles nibbles into 12-bit pixel words. It finds that lane's word boundary on its own by searching every nibble offset for a sync marker. It then holds back the earlier lanes in small per-lane delay queues until all four present corresponding words in the same cycle.

The result is a 48-bit bundle of four aligned pixel words, a one-cycle strobe for each bundle, and a flag that rises once every lane is word-locked and the lanes are mutually aligned. A downstream stage merges the four words into a single pixel stream; that stage is not part of this block.

Top module: `lane_word_deskew`

## Requirements
- R1: While rst_n is low (active-low, asynchronous), word_vld, locked and word_bundle are all zero.
- R2: Lane g is taken from lanes_in[4g+3:4g], with lane 0 = channel 1 port 0, lane 1 = channel 1 port 1, lane 2 = channel 2 port 0 and lane 3 = channel 2 port 1. Its words appear at word_bundle[12g+11:12g]. The earliest of the three nibbles forming a word is placed in bits [11:8] and the latest in bits [3:0].
- R3: Each lane locks independently on the first 24-bit run of nibbles equal to 0xFFF followed by 0x000, at whichever of the three nibble offsets it occurs. The 0x000 word is that lane's marker word.
- R4: Once a lane is locked, its word boundary is kept until reset, even if the nibble pattern 0xFFF000 later appears across word boundaries in the data.
- R5: The first bundle holds the four marker words (all zero). Bundle n after it holds the n-th word each lane sent after its marker.
- R6: Skew between lanes of up to four words plus any nibble offset is absorbed with no loss of data.
- R7: locked rises in the same cycle as the first word_vld and stays high until reset.
- R8: After lock, word_vld is high for exactly one cycle in every three.
- R9: While any lane has not found its marker, word_vld and locked stay low.
- R10: word_vld is first high after the third rising edge that follows the edge capturing the last marker nibble of the latest lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-rate lane clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lanes_in | input | 16 | Four 4-bit lane nibbles, lane 0 in the low nibble |
| word_bundle | output | 48 | Four aligned 12-bit words, lane 0 in the low bits |
| word_vld | output | 1 | One-cycle strobe for each new bundle |
| locked | output | 1 | All lanes word-locked and mutually aligned |

## Verification
Four lane patterns are applied.
- With identical offsets on all lanes, the basic packing and nibble order are checked.
- With a different nibble offset on each lane, each lane must lock on its own phase. This separates a per-lane boundary search from one shared across lanes.
- With a skew of more than four words between lanes, the check confirms that the delay queues release marker words together, rather than releasing whatever happens to be at their heads.
- With one lane that never sends a marker, the check confirms that nothing is produced.

The marker pattern is also embedded across data words on one lane, which shows that a lane does not relock after its boundary is fixed.

// File: rtl/lwd_pkg.sv
package lwd_pkg;

  localparam int NIB_W         = 4;
  localparam int NIBS_PER_WORD = 3;
  localparam int WORD_W        = NIB_W * NIBS_PER_WORD;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic  marker;
    word_t data;
  } lane_entry_t;

  // Sync run: one word of all ones directly followed by one word of zeros.
  function automatic logic sync_hit(input logic [2*WORD_W-1:0] win);
    return win == {{WORD_W{1'b1}}, {WORD_W{1'b0}}};
  endfunction

endpackage

// File: rtl/lwd_lane_aligner.sv
module lwd_lane_aligner
  import lwd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NIB_W-1:0] nib_in,
  output logic             push_o,
  output lane_entry_t      entry_o,
  output logic             locked_o
);

  localparam int HIST_W = 2 * WORD_W;
  localparam int PH_W   = $clog2(NIBS_PER_WORD);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(NIBS_PER_WORD - 1);

  logic [HIST_W-1:0] hist_q;
  logic [PH_W-1:0]   phase_q;
  logic              lock_q;
  logic              hit;
  logic              emit;

  // The history window slides one nibble per cycle, so all three
  // candidate offsets are tried one after another.
  assign hit  = !lock_q && sync_hit(hist_q);
  assign emit = lock_q && (phase_q == PH_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q  <= '0;
      phase_q <= '0;
      lock_q  <= 1'b0;
      push_o  <= 1'b0;
      entry_o <= '0;
    end else begin
      hist_q <= {hist_q[HIST_W-NIB_W-1:0], nib_in};
      if (hit) begin
        lock_q  <= 1'b1;
        phase_q <= '0;
      end else if (lock_q) begin
        phase_q <= emit ? '0 : phase_q + 1'b1;
      end
      push_o         <= hit || emit;
      entry_o.marker <= hit;
      entry_o.data   <= hist_q[WORD_W-1:0];
    end
  end

  assign locked_o = lock_q;

endmodule

// File: rtl/lwd_lane_fifo.sv
module lwd_lane_fifo
  import lwd_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  lane_entry_t wr_data,
  input  logic        rd_en,
  output lane_entry_t rd_data,
  output logic        nonempty,
  output logic        full
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  lane_entry_t        mem [DEPTH];
  logic [PTR_W-1:0]   wr_ptr;
  logic [PTR_W-1:0]   rd_ptr;
  logic [CNT_W-1:0]   cnt;
  logic               do_wr;
  logic               do_rd;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (cnt == CNT_W'(DEPTH));
  assign nonempty = (cnt != '0);
  assign do_wr    = wr_en && !full;
  assign do_rd    = rd_en && nonempty;
  assign rd_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_wr) wr_ptr <= bump(wr_ptr);
      if (do_rd) rd_ptr <= bump(rd_ptr);
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/lwd_deskew_ctrl.sv
module lwd_deskew_ctrl
  import lwd_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        lane_ready,
  input  logic [LANES-1:0]        head_marker,
  input  logic [LANES*WORD_W-1:0] head_data,
  output logic                    pop_o,
  output logic [LANES*WORD_W-1:0] bundle_o,
  output logic                    vld_o,
  output logic                    aligned_o
);

  // Every queue starts with its marker, so releasing only when all
  // queues hold a word lines the markers up and keeps them lined up.
  assign pop_o = &lane_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o     <= 1'b0;
      bundle_o  <= '0;
      aligned_o <= 1'b0;
    end else begin
      vld_o <= pop_o;
      if (pop_o) bundle_o <= head_data;
      if (pop_o && (&head_marker)) aligned_o <= 1'b1;
    end
  end

endmodule

// File: rtl/lane_word_deskew.sv
module lane_word_deskew
  import lwd_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int FIFO_DEPTH = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES*NIB_W-1:0]  lanes_in,
  output logic [LANES*WORD_W-1:0] word_bundle,
  output logic                    word_vld,
  output logic                    locked
);

  lane_entry_t             al_entry   [LANES];
  lane_entry_t             head_entry [LANES];
  logic [LANES-1:0]        lane_push;
  logic [LANES-1:0]        lane_lock;
  logic [LANES-1:0]        lane_ready;
  logic [LANES-1:0]        lane_full;
  logic [LANES-1:0]        head_marker;
  logic [LANES*WORD_W-1:0] head_data;
  logic                    pop;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lwd_lane_aligner u_align (
      .clk      (clk),
      .rst_n    (rst_n),
      .nib_in   (lanes_in[g*NIB_W +: NIB_W]),
      .push_o   (lane_push[g]),
      .entry_o  (al_entry[g]),
      .locked_o (lane_lock[g])
    );

    lwd_lane_fifo #(.DEPTH(FIFO_DEPTH)) u_queue (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (lane_push[g]),
      .wr_data  (al_entry[g]),
      .rd_en    (pop),
      .rd_data  (head_entry[g]),
      .nonempty (lane_ready[g]),
      .full     (lane_full[g])
    );

    assign head_marker[g]                 = head_entry[g].marker;
    assign head_data[g*WORD_W +: WORD_W]  = head_entry[g].data;
  end

  lwd_deskew_ctrl #(.LANES(LANES)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .lane_ready  (lane_ready),
    .head_marker (head_marker),
    .head_data   (head_data),
    .pop_o       (pop),
    .bundle_o    (word_bundle),
    .vld_o       (word_vld),
    .aligned_o   (locked)
  );

endmodule

// File: rtl/lwd_checker.sv
module lwd_checker #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             word_vld,
  input logic             locked,
  input logic [LANES-1:0] lane_lock,
  input logic [LANES-1:0] lane_push,
  input logic [LANES-1:0] lane_full,
  input logic [LANES-1:0] head_marker,
  input logic             pop
);

  logic [LANES-1:0] lock_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_prev <= '0;
    else        lock_prev <= lane_lock;
  end

  p_lane_lock_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_prev & ~lane_lock) == '0);

  p_locked_needs_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (&lane_lock));

  p_first_release_markers_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !locked) |-> (&head_marker));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_push & lane_full) == '0);

  p_locked_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  p_vld_with_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> locked);

  p_vld_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> !word_vld ##1 !word_vld);

endmodule

bind lane_word_deskew lwd_checker #(.LANES(LANES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .word_vld    (word_vld),
  .locked      (locked),
  .lane_lock   (lane_lock),
  .lane_push   (lane_push),
  .lane_full   (lane_full),
  .head_marker (head_marker),
  .pop         (pop)
);

// File: tb/sim_lane_word_deskew.sv
module sim_lane_word_deskew;

  localparam int NMAX = 60;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] lanes_in = 16'hAAAA;
  logic [47:0] word_bundle;
  logic        word_vld;
  logic        locked;

  int checks = 0;
  int fails  = 0;
  int pre [4];
  logic        vld_s [NMAX];
  logic        lock_s[NMAX];
  logic [47:0] bun_s [NMAX];

  always #2 clk = ~clk;

  lane_word_deskew u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .lanes_in    (lanes_in),
    .word_bundle (word_bundle),
    .word_vld    (word_vld),
    .locked      (locked)
  );

  // Lane 0 words 1..3 carry the nibble run F,F,F,0,0,0 across word edges (R4).
  function automatic logic [11:0] lane_word(input int i, input int n);
    if (i == 0 && n == 1) return 12'hAFF;
    if (i == 0 && n == 2) return 12'hF00;
    if (i == 0 && n == 3) return 12'h0AB;
    return 12'((i * 273 + n * 37 + 60) % 4000);
  endfunction

  function automatic logic [3:0] lane_nib(input int i, input int j);
    int r;
    if (j < pre[i])     return 4'hA;
    if (j < pre[i] + 3) return 4'hF;
    if (j < pre[i] + 6) return 4'h0;
    r = j - pre[i] - 6;
    return 4'((lane_word(i, r / 3) >> (4 * (2 - r % 3))) & 12'hF);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    lanes_in = 16'hAAAA;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_stream(input int p0, input int p1, input int p2, input int p3, input int len);
    pre[0] = p0; pre[1] = p1; pre[2] = p2; pre[3] = p3;
    do_reset();
    for (int j = 0; j < len; j++) begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) lanes_in[i*4 +: 4] = lane_nib(i, j);
      @(posedge clk);
      #1;
      vld_s[j]  = word_vld;
      lock_s[j] = locked;
      bun_s[j]  = word_bundle;
    end
  endtask

  task automatic check_aligned(input string tag);
    int kmax = 0;
    int first;
    bit quiet = 1'b1;
    for (int i = 0; i < 4; i++) if (pre[i] + 5 > kmax) kmax = pre[i] + 5;
    first = kmax + 3;
    for (int j = 0; j < first; j++) if (vld_s[j] !== 1'b0) quiet = 1'b0;
    chk(quiet, {tag, " R9 quiet before lock"}, 48'(quiet), 48'd1);
    chk(vld_s[first] === 1'b1, {tag, " R10 first strobe cycle"}, 48'(vld_s[first]), 48'd1);
    chk(lock_s[first] === 1'b1 && lock_s[first-1] === 1'b0, {tag, " R7 lock edge"},
        48'({lock_s[first-1], lock_s[first]}), 48'b01);
    chk(bun_s[first] === 48'd0, {tag, " R5 marker bundle"}, bun_s[first], 48'd0);
    for (int n = 1; n <= 4; n++) begin
      int idx = first + 3 * n;
      logic [47:0] exp;
      for (int i = 0; i < 4; i++) exp[i*12 +: 12] = lane_word(i, n - 1);
      chk(vld_s[idx] === 1'b1 && vld_s[idx-1] === 1'b0 && vld_s[idx-2] === 1'b0,
          {tag, " R8 strobe spacing"}, 48'({vld_s[idx-2], vld_s[idx-1], vld_s[idx]}), 48'b001);
      chk(bun_s[idx] === exp, {tag, " R2 R5 bundle content"}, bun_s[idx], exp);
      chk(bun_s[idx][11:0] === lane_word(0, n - 1), {tag, " R4 lane0 word kept"},
          48'(bun_s[idx][11:0]), 48'(lane_word(0, n - 1)));
      chk(lock_s[idx] === 1'b1, {tag, " R7 lock held"}, 48'(lock_s[idx]), 48'd1);
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(word_vld === 1'b0 && locked === 1'b0 && word_bundle === 48'd0, "R1 after reset",
        {46'd0, word_vld, locked}, 48'd0);
  endtask

  task automatic t_same_offset();
    run_stream(3, 3, 3, 3, NMAX);
    check_aligned("same-offset R2");
  endtask

  task automatic t_mixed_offsets();
    run_stream(3, 4, 5, 7, NMAX);
    check_aligned("mixed-offset R3");
  endtask

  task automatic t_word_skew();
    run_stream(2, 15, 5, 16, NMAX);
    check_aligned("word-skew R6");
  endtask

  task automatic t_stuck_lane();
    bit quiet = 1'b1;
    run_stream(3, 3, 3, 500, 30);
    for (int j = 0; j < 30; j++) if (vld_s[j] !== 1'b0 || lock_s[j] !== 1'b0) quiet = 1'b0;
    chk(quiet, "R9 stuck lane keeps output idle", 48'(quiet), 48'd1);
  endtask

  task automatic t_reset_mid();
    run_stream(3, 3, 3, 3, NMAX);
    chk(locked === 1'b1, "R7 locked before mid reset", 48'(locked), 48'd1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(word_vld === 1'b0 && locked === 1'b0 && word_bundle === 48'd0, "R1 mid-run reset",
        {46'd0, word_vld, locked}, 48'd0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  bit done = 1'b0;

  initial begin
    #(4 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_same_offset();
    t_mixed_offsets();
    t_word_skew();
    t_stuck_lane();
    t_reset_mid();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule